// File: doc/BRIEF.md
# Two-Port Relay Forwarding Classifier

This block sits on the receive side of one port of a two-port Ethernet relay and chooses where each incoming frame goes. It counts the bytes of the frame as they arrive. It keeps the destination address and the EtherType. When a fixed number of header bytes has been seen, it makes one registered decision. That decision says whether the frame is delivered to the local host and how it is passed to the opposite port: not at all, cut straight through, or queued and sent after the whole frame has arrived. It also says whether the frame must go through the storm-prevention check.

Ring-redundancy frames and time-sync frames are recognised by their EtherType. They are not sent to the storm check. When a frame would be cut through but the opposite transmitter is busy, the block chooses queued forwarding instead. At the end of the frame, a queued frame is either released or dropped, depending on the frame check status. Cut-through frames have already left the port by then, so their check status is ignored.

A frame ends with a strobe cycle that carries no data byte. The decision stays on the outputs until that strobe, and the outputs return to zero on the following cycle.

Top module: `relay_fwd_classifier`

## Requirements
- R1: The decision flag `dec_valid_o` rises in the cycle after the 22nd data byte of a frame is accepted, and it is low before that.
- R2: A destination of all-ones (broadcast) with an ordinary EtherType gives host=1 and storm=1. With the opposite link up and the opposite port idle, it gives mode=cut, where mode encodes 00 none, 01 cut, 10 store.
- R3: A destination whose first byte has bit 0 set, that is not broadcast and has an ordinary EtherType (multicast), is handled exactly like broadcast.
- R4: EtherType 0x80E1 (ring protocol) gives protocol class 01, storm=0, host=1 and cut-through forwarding, whatever the destination.
- R5: EtherType 0x88F7 (time sync) gives protocol class 10, storm=0, host=1 and cut-through forwarding; ordinary frames give class 00.
- R6: A unicast destination (first byte bit 0 clear) equal to all 48 bits of the local MAC gives host=1, mode=none and storm=0, even when the opposite port is busy.
- R7: A unicast destination that differs from the local MAC in any bit gives host=0, storm=0 and mode=cut.
- R8: If the mode would be cut and the opposite port is busy in the decision cycle, the mode becomes store (10).
- R9: If the opposite link is down in the decision cycle, the mode is none for every frame class.
- R10: The decision outputs do not change between the decision and the end-of-frame strobe, even if the link or busy inputs change. All of them are zero in the cycle after the strobe. A frame shorter than 22 bytes produces no decision.
- R11: In the cycle after the end-of-frame strobe, a store-mode frame pulses `sf_release_o` if its FCS is good and `sf_drop_o` if it is bad. Frames in none or cut mode pulse neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_eof_i | input | 1 | End-of-frame strobe, given in a cycle with no byte |
| rx_fcs_err_i | input | 1 | FCS error status, valid while rx_eof_i is high |
| local_mac_i | input | 48 | Interface MAC address, first byte on the wire in bits 47:40 |
| peer_link_i | input | 1 | Opposite port link is up |
| peer_busy_i | input | 1 | Opposite transmitter is in use |
| dec_valid_o | output | 1 | Decision is held on the outputs |
| host_o | output | 1 | Deliver the frame to the host |
| fwd_mode_o | output | 2 | 00 none, 01 cut-through, 10 store-then-forward |
| storm_chk_o | output | 1 | Frame must pass the storm check |
| proto_o | output | 2 | 00 ordinary, 01 ring, 10 time sync |
| sf_release_o | output | 1 | Queued frame may be sent |
| sf_drop_o | output | 1 | Queued frame is discarded |

## Verification
The assertions assume that `rx_eof_i` never arrives in the same cycle as a byte strobe. They also assume that the FCS status means something only while the strobe is high. The bench drives every byte and every end strobe on separate cycles. It holds `rx_fcs_err_i` low except during the strobe. It changes the link and busy inputs only at frame start or after the decision, and the latter is done on purpose to test that the decision is held.

// File: rtl/relay_fwd_pkg.sv
package relay_fwd_pkg;
  localparam int unsigned MAC_W = 48;

  typedef enum logic [1:0] {
    FWD_NONE  = 2'b00,
    FWD_CUT   = 2'b01,
    FWD_STORE = 2'b10
  } fwd_mode_e;

  typedef enum logic [1:0] {
    PROTO_PLAIN = 2'b00,
    PROTO_RING  = 2'b01,
    PROTO_SYNC  = 2'b10
  } proto_e;

  typedef struct packed {
    logic      host;
    fwd_mode_e mode;
    logic      storm;
    proto_e    proto;
  } fwd_dec_t;
endpackage

// File: rtl/relay_hdr_capture.sv
module relay_hdr_capture #(
  parameter int unsigned DECIDE_BYTES = 22,
  parameter int unsigned MAC_BYTES    = 6,
  parameter int unsigned TYPE_OFFSET  = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rx_valid_i,
  input  logic [7:0]             rx_data_i,
  input  logic                   rx_eof_i,
  output logic [MAC_BYTES*8-1:0] dst_o,
  output logic [15:0]            etype_o,
  output logic                   hdr_done_o
);
  localparam int unsigned CNT_W = $clog2(DECIDE_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DECIDE_BYTES - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(DECIDE_BYTES);
  localparam logic [CNT_W-1:0] CNT_DST  = CNT_W'(MAC_BYTES);
  localparam logic [CNT_W-1:0] CNT_T0   = CNT_W'(TYPE_OFFSET);
  localparam logic [CNT_W-1:0] CNT_T1   = CNT_W'(TYPE_OFFSET + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      dst_o   <= '0;
      etype_o <= '0;
    end else if (rx_eof_i) begin
      cnt_q <= '0;
    end else if (rx_valid_i) begin
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      if (cnt_q < CNT_DST) dst_o <= {dst_o[MAC_BYTES*8-9:0], rx_data_i};
      if (cnt_q == CNT_T0) etype_o[15:8] <= rx_data_i;
      if (cnt_q == CNT_T1) etype_o[7:0]  <= rx_data_i;
    end
  end

  assign hdr_done_o = rx_valid_i && (cnt_q == CNT_LAST);
endmodule

// File: rtl/relay_fwd_decide.sv
module relay_fwd_decide
  import relay_fwd_pkg::*;
#(
  parameter logic [15:0] RING_TYPE = 16'h80E1,
  parameter logic [15:0] SYNC_TYPE = 16'h88F7
) (
  input  logic [MAC_W-1:0] dst_i,
  input  logic [15:0]      etype_i,
  input  logic [MAC_W-1:0] local_mac_i,
  input  logic             peer_link_i,
  input  logic             peer_busy_i,
  output fwd_dec_t         dec_o
);
  logic is_group, is_bcast, is_ring, is_sync, is_mine, want_cut;

  always_comb begin
    is_group = dst_i[MAC_W-8];
    is_bcast = &dst_i;
    is_ring  = (etype_i == RING_TYPE);
    is_sync  = (etype_i == SYNC_TYPE);
    is_mine  = !is_group && (dst_i == local_mac_i);

    dec_o.proto = is_ring ? PROTO_RING : (is_sync ? PROTO_SYNC : PROTO_PLAIN);
    // Protocol frames bypass storm handling and use their own path
    if (is_ring || is_sync) begin
      dec_o.host  = 1'b1;
      dec_o.storm = 1'b0;
      want_cut    = 1'b1;
    end else if (is_bcast || is_group) begin
      dec_o.host  = 1'b1;
      dec_o.storm = 1'b1;
      want_cut    = 1'b1;
    end else if (is_mine) begin
      dec_o.host  = 1'b1;
      dec_o.storm = 1'b0;
      want_cut    = 1'b0;
    end else begin
      dec_o.host  = 1'b0;
      dec_o.storm = 1'b0;
      want_cut    = 1'b1;
    end

    if (!want_cut || !peer_link_i) dec_o.mode = FWD_NONE;
    else if (peer_busy_i)          dec_o.mode = FWD_STORE;
    else                           dec_o.mode = FWD_CUT;
  end
endmodule

// File: rtl/relay_fwd_classifier.sv
module relay_fwd_classifier
  import relay_fwd_pkg::*;
#(
  parameter int unsigned DECIDE_BYTES = 22,
  parameter logic [15:0] RING_TYPE    = 16'h80E1,
  parameter logic [15:0] SYNC_TYPE    = 16'h88F7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_eof_i,
  input  logic        rx_fcs_err_i,
  input  logic [47:0] local_mac_i,
  input  logic        peer_link_i,
  input  logic        peer_busy_i,
  output logic        dec_valid_o,
  output logic        host_o,
  output logic [1:0]  fwd_mode_o,
  output logic        storm_chk_o,
  output logic [1:0]  proto_o,
  output logic        sf_release_o,
  output logic        sf_drop_o
);
  logic [MAC_W-1:0] dst;
  logic [15:0]      etype;
  logic             hdr_done;
  fwd_dec_t         dec_d, dec_q;
  logic             valid_q;

  relay_hdr_capture #(
    .DECIDE_BYTES(DECIDE_BYTES),
    .MAC_BYTES   (MAC_W / 8),
    .TYPE_OFFSET (2 * (MAC_W / 8))
  ) u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_valid_i(rx_valid_i),
    .rx_data_i (rx_data_i),
    .rx_eof_i  (rx_eof_i),
    .dst_o     (dst),
    .etype_o   (etype),
    .hdr_done_o(hdr_done)
  );

  relay_fwd_decide #(
    .RING_TYPE(RING_TYPE),
    .SYNC_TYPE(SYNC_TYPE)
  ) u_decide (
    .dst_i      (dst),
    .etype_i    (etype),
    .local_mac_i(local_mac_i),
    .peer_link_i(peer_link_i),
    .peer_busy_i(peer_busy_i),
    .dec_o      (dec_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q      <= 1'b0;
      dec_q        <= '0;
      sf_release_o <= 1'b0;
      sf_drop_o    <= 1'b0;
    end else if (rx_eof_i) begin
      sf_release_o <= valid_q && (dec_q.mode == FWD_STORE) && !rx_fcs_err_i;
      sf_drop_o    <= valid_q && (dec_q.mode == FWD_STORE) &&  rx_fcs_err_i;
      valid_q      <= 1'b0;
      dec_q        <= '0;
    end else begin
      sf_release_o <= 1'b0;
      sf_drop_o    <= 1'b0;
      if (hdr_done && !valid_q) begin
        valid_q <= 1'b1;
        dec_q   <= dec_d;
      end
    end
  end

  assign dec_valid_o = valid_q;
  assign host_o      = dec_q.host;
  assign fwd_mode_o  = dec_q.mode;
  assign storm_chk_o = dec_q.storm;
  assign proto_o     = dec_q.proto;
endmodule

// File: rtl/relay_fwd_classifier_chk.sv
module relay_fwd_classifier_chk #(
  parameter int unsigned DECIDE_BYTES = 22
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_valid_i,
  input logic       rx_eof_i,
  input logic       peer_busy_i,
  input logic       peer_link_i,
  input logic       dec_valid_o,
  input logic       host_o,
  input logic [1:0] fwd_mode_o,
  input logic       storm_chk_o,
  input logic [1:0] proto_o,
  input logic       sf_release_o,
  input logic       sf_drop_o
);
  localparam int unsigned CW = $clog2(DECIDE_BYTES + 2);
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     seen_q <= '0;
    else if (rx_eof_i)                               seen_q <= '0;
    else if (rx_valid_i && seen_q != CW'(DECIDE_BYTES)) seen_q <= seen_q + 1'b1;
  end

  a_r1_decide_at_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dec_valid_o) |-> seen_q == CW'(DECIDE_BYTES));

  a_r4_proto_no_storm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && proto_o != 2'b00) |-> !storm_chk_o && host_o);

  a_r8_busy_not_cut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dec_valid_o) && fwd_mode_o == 2'b01) |-> !$past(peer_busy_i));

  a_r9_link_down_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dec_valid_o) && !$past(peer_link_i)) |-> fwd_mode_o == 2'b00);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !rx_eof_i) |=> dec_valid_o && $stable(fwd_mode_o) &&
      $stable(host_o) && $stable(storm_chk_o) && $stable(proto_o));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_eof_i |=> !dec_valid_o && fwd_mode_o == 2'b00 && !host_o);

  a_r11_store_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_release_o || sf_drop_o) |-> $past(fwd_mode_o) == 2'b10 && $past(rx_eof_i));

  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sf_release_o && sf_drop_o) && fwd_mode_o != 2'b11);
endmodule

bind relay_fwd_classifier relay_fwd_classifier_chk #(.DECIDE_BYTES(DECIDE_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .rx_eof_i    (rx_eof_i),
  .peer_busy_i (peer_busy_i),
  .peer_link_i (peer_link_i),
  .dec_valid_o (dec_valid_o),
  .host_o      (host_o),
  .fwd_mode_o  (fwd_mode_o),
  .storm_chk_o (storm_chk_o),
  .proto_o     (proto_o),
  .sf_release_o(sf_release_o),
  .sf_drop_o   (sf_drop_o)
);

// File: tb/relay_fwd_classifier_bench.sv
module relay_fwd_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] MY_MAC = 48'h02_11_22_33_44_55;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_eof_i = 1'b0;
  logic        rx_fcs_err_i = 1'b0;
  logic        peer_link_i = 1'b1;
  logic        peer_busy_i = 1'b0;
  logic        dec_valid_o, host_o, storm_chk_o, sf_release_o, sf_drop_o;
  logic [1:0]  fwd_mode_o, proto_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  relay_fwd_classifier u_relay_fwd_classifier (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .rx_eof_i(rx_eof_i), .rx_fcs_err_i(rx_fcs_err_i), .local_mac_i(MY_MAC),
    .peer_link_i(peer_link_i), .peer_busy_i(peer_busy_i), .dec_valid_o(dec_valid_o),
    .host_o(host_o), .fwd_mode_o(fwd_mode_o), .storm_chk_o(storm_chk_o),
    .proto_o(proto_o), .sf_release_o(sf_release_o), .sf_drop_o(sf_drop_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_dec(input string tag, input int h, input int m, input int s, input int p);
    chk({tag, " valid"}, dec_valid_o, 1);
    chk({tag, " host"},  host_o, h);
    chk({tag, " mode"},  fwd_mode_o, m);
    chk({tag, " storm"}, storm_chk_o, s);
    chk({tag, " proto"}, proto_o, p);
  endtask

  // One frame: header, decision check, hold check, end strobe and release/drop check
  task automatic run_frame(input string tag, input logic [47:0] dst, input logic [15:0] et,
                           input logic link, input logic busy, input logic fcs_err,
                           input int h, input int m, input int s, input int p);
    peer_link_i = link;
    peer_busy_i = busy;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (i == 21) chk({tag, " R1 no early decision"}, dec_valid_o, 0);
      if (i == 22) begin
        check_dec({tag, " R1 decision"}, h, m, s, p);
        peer_busy_i = ~busy;  // R10: late change must not alter decision
        peer_link_i = ~link;
      end
      rx_valid_i = 1'b1;
      if (i < 6)        rx_data_i = dst[47-8*i -: 8];
      else if (i == 12) rx_data_i = et[15:8];
      else if (i == 13) rx_data_i = et[7:0];
      else              rx_data_i = 8'(i);
    end
    @(negedge clk_i);
    rx_valid_i = 1'b0;
    @(negedge clk_i);
    check_dec({tag, " R10 held"}, h, m, s, p);
    rx_eof_i     = 1'b1;
    rx_fcs_err_i = fcs_err;
    @(negedge clk_i);
    rx_eof_i     = 1'b0;
    rx_fcs_err_i = 1'b0;
    chk({tag, " R10 cleared valid"}, dec_valid_o, 0);
    chk({tag, " R10 cleared mode"}, fwd_mode_o, 0);
    chk({tag, " R11 release"}, sf_release_o, (m == 2 && !fcs_err) ? 1 : 0);
    chk({tag, " R11 drop"}, sf_drop_o, (m == 2 && fcs_err) ? 1 : 0);
    @(negedge clk_i);
    chk({tag, " R11 pulse single"}, sf_release_o | sf_drop_o, 0);
  endtask

  task automatic run_short;
    peer_link_i = 1'b1;
    peer_busy_i = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk_i);
      rx_valid_i = 1'b1;
      rx_data_i  = 8'hFF;
    end
    @(negedge clk_i);
    rx_valid_i = 1'b0;
    rx_eof_i   = 1'b1;
    @(negedge clk_i);
    rx_eof_i = 1'b0;
    chk("R10 short frame no decision", dec_valid_o, 0);
    chk("R10 short frame host", host_o, 0);
    chk("R11 short frame release", sf_release_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 reset valid", dec_valid_o, 0);
    chk("R10 reset mode", fwd_mode_o, 0);
    chk("R11 reset drop", sf_drop_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_frame("R2 bcast",          48'hFFFF_FFFF_FFFF, 16'h0800, 1, 0, 0, 1, 1, 1, 0);
    run_frame("R9 bcast link down", 48'hFFFF_FFFF_FFFF, 16'h0800, 0, 0, 0, 1, 0, 1, 0);
    run_frame("R3 mcast",          48'h0100_5E00_0001, 16'h0800, 1, 0, 0, 1, 1, 1, 0);
    run_frame("R4 ring",           48'h0121_6C00_0001, 16'h80E1, 1, 0, 0, 1, 1, 0, 1);
    run_frame("R4 ring busy",      48'h0121_6C00_0001, 16'h80E1, 1, 1, 1, 1, 2, 0, 1);
    run_frame("R5 sync",           48'h011B_1900_0000, 16'h88F7, 1, 0, 0, 1, 1, 0, 2);
    run_frame("R6 unicast mine",   MY_MAC,             16'h0800, 1, 1, 0, 1, 0, 0, 0);
    run_frame("R7 unicast other",  48'h0211_2233_4456, 16'h0800, 1, 0, 1, 0, 1, 0, 0);
    run_frame("R7 unicast top byte", 48'h0611_2233_4455, 16'h0800, 1, 0, 0, 0, 1, 0, 0);
    run_frame("R8 unicast busy",   48'h0211_2233_4456, 16'h0800, 1, 1, 0, 0, 2, 0, 0);
    run_frame("R11 store fcs bad", 48'h0211_2233_4456, 16'h0800, 1, 1, 1, 0, 2, 0, 0);
    run_frame("R8 bcast busy",     48'hFFFF_FFFF_FFFF, 16'h0806, 1, 1, 0, 1, 2, 1, 0);
    run_frame("R9 unicast down",   48'h0211_2233_4456, 16'h0800, 0, 1, 0, 0, 0, 0, 0);
    run_short();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule